// File: doc/BRIEF.md
# Mode Register Decoder with Read-Latency Scheduler

This block sits in a DDR memory controller's command path. It interprets mode-register load commands and keeps three settings:

- the burst length code;
- the burst ordering, either sequential or interleaved;
- the read latency, either two full clocks or two and a half clocks.

It also reports misuse of reserved codes. When a command targets the DLL-reset operating mode, it issues a one-tick DLL-reset request.

For every READ command it accepts, the block produces a single-tick marker on the tick when the first read data is due. The marker then triggers the data capture path, which is not part of this block.

The block is clocked by a double-rate tick, so each memory clock spans two ticks. The `rise_i` input marks the ticks that coincide with a rising memory-clock edge, and commands are registered only on those ticks. Because of this, the 2.5-clock latency can be expressed exactly. Its marker lands on a falling-edge tick and is flagged separately by `first_half_o`.

Top module: `mrs_rdlat_sched`

## Requirements
- R1: After reset, the block holds burst code 3'b001, sequential order (`interleave_o`=0), latency 2 (`half_lat_o`=0), no error, and no marker or DLL request.
- R2: A load or read presented on a tick with `rise_i`=0 is ignored: no field, error flag, DLL request or data marker results from it.
- R3: A load with `bank_i` other than 2'b00 changes no field and raises neither the error flag nor the DLL request.
- R4: A valid base load takes the burst code from `addr_i[2:0]` (3'b001, 3'b010, 3'b011 = 2, 4, 8 beats), the order from `addr_i[3]` (1 = interleaved) and the latency from `addr_i[6:4]` (3'b010 = 2 clocks, 3'b110 = 2.5 clocks). The fields are visible on the tick after the accepting edge.
- R5: A base load whose burst code, latency code or operating-mode field is reserved sets `cfg_err_o` on the next tick. All previous fields are kept and no DLL request is made.
- R6: The operating-mode field is `addr_i[13:7]`. All zeros means normal operation. The value with only `addr_i[8]` set also asserts `dll_reset_o` for exactly the one tick after the accepting edge, and that load still updates the fields.
- R7: A read accepted at tick edge E while latency 2 is held raises `first_data_o` for exactly the one tick following edge E+4, with `first_half_o` low.
- R8: A read accepted at edge E while latency 2.5 is held raises both `first_data_o` and `first_half_o` for exactly the one tick following edge E+5.
- R9: A read uses the latency held before its accepting edge. A load accepted at the same edge affects only later reads.
- R10: Reads accepted on every rising tick each produce their own marker, with no loss or merging.
- R11: `cfg_err_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate tick clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rise_i | input | 1 | This tick coincides with a rising memory-clock edge |
| load_i | input | 1 | Mode-register load command |
| read_i | input | 1 | READ command |
| bank_i | input | 2 | Bank-address bits selecting the target register |
| addr_i | input | 14 | Address bus carrying the mode value |
| bl_code_o | output | 3 | Held burst-length code |
| interleave_o | output | 1 | Held burst order, 1 = interleaved |
| half_lat_o | output | 1 | Held latency, 1 = 2.5 clocks |
| dll_reset_o | output | 1 | One-tick DLL-reset request |
| cfg_err_o | output | 1 | Sticky reserved-code error |
| first_data_o | output | 1 | First read data is due this tick |
| first_half_o | output | 1 | The due marker is on a half-clock tick |

## Verification
A load and a read can be accepted on the same rising tick. In that case the latency update and the read scheduling race for the same edge. The bench provokes this with a load that switches the latency while a read is issued on that edge, followed at once by more reads. Its per-tick expectation ring schedules each read with the latency its model held before the load was applied, so the marker must appear at the old offset for that read and at the new offset for every read after it.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  // Held mode settings
  typedef struct packed {
    logic [2:0] bl;    // burst-length code
    logic       il;    // 1 = interleaved order
    logic       half;  // 1 = 2.5-clock latency
  } mode_cfg_t;

  localparam logic [2:0] BL_CODE_2  = 3'b001;
  localparam logic [2:0] BL_CODE_4  = 3'b010;
  localparam logic [2:0] BL_CODE_8  = 3'b011;
  localparam logic [2:0] CL_CODE_2  = 3'b010;
  localparam logic [2:0] CL_CODE_25 = 3'b110;

  // Field positions on the address bus
  localparam int BL_LSB = 0;
  localparam int BT_POS = 3;
  localparam int CL_LSB = 4;
  localparam int OP_LSB = 7;
  localparam int DLL_POS = 8;

  // Latency in ticks (two ticks per memory clock)
  localparam int LAT_FULL_TICKS = 4;
  localparam int LAT_HALF_TICKS = 5;

  localparam mode_cfg_t RESET_CFG = '{bl: BL_CODE_2, il: 1'b0, half: 1'b0};

endpackage

// File: rtl/mrs_field_decode.sv
module mrs_field_decode
  import mrs_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr_i,
  output mode_cfg_t         cand_o,
  output logic              bad_o,
  output logic              dll_req_o
);

  localparam int OP_W = ADDR_W - OP_LSB;
  localparam logic [OP_W-1:0] OP_NORMAL = '0;
  localparam logic [OP_W-1:0] OP_DLL    = OP_W'(1) << (DLL_POS - OP_LSB);

  logic [2:0]      bl_code;
  logic [2:0]      cl_code;
  logic [OP_W-1:0] op_code;
  logic            bl_bad, cl_bad, op_bad;

  assign bl_code = addr_i[BL_LSB +: 3];
  assign cl_code = addr_i[CL_LSB +: 3];
  assign op_code = addr_i[ADDR_W-1:OP_LSB];

  always_comb begin
    case (bl_code)
      BL_CODE_2, BL_CODE_4, BL_CODE_8: bl_bad = 1'b0;
      default:                         bl_bad = 1'b1;
    endcase
  end

  always_comb begin
    case (cl_code)
      CL_CODE_2, CL_CODE_25: cl_bad = 1'b0;
      default:               cl_bad = 1'b1;
    endcase
  end

  always_comb begin
    op_bad    = 1'b1;
    dll_req_o = 1'b0;
    if (op_code == OP_NORMAL) begin
      op_bad = 1'b0;
    end else if (op_code == OP_DLL) begin
      op_bad    = 1'b0;
      dll_req_o = 1'b1;
    end
  end

  assign bad_o       = bl_bad | cl_bad | op_bad;
  assign cand_o.bl   = bl_code;
  assign cand_o.il   = addr_i[BT_POS];
  assign cand_o.half = (cl_code == CL_CODE_25);

endmodule

// File: rtl/mrs_cfg_reg.sv
module mrs_cfg_reg
  import mrs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_ok_i,
  input  mode_cfg_t cand_i,
  input  logic      bad_i,
  input  logic      dll_req_i,
  output mode_cfg_t cfg_o,
  output logic      err_o,
  output logic      dll_pulse_o
);

  mode_cfg_t cfg_q, cfg_d;
  logic      err_q, err_d;
  logic      dll_q, dll_d;

  always_comb begin
    cfg_d = cfg_q;
    err_d = err_q;
    dll_d = 1'b0;
    if (load_ok_i) begin
      if (bad_i) begin
        err_d = 1'b1;
      end else begin
        cfg_d = cand_i;
        dll_d = dll_req_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= RESET_CFG;
      err_q <= 1'b0;
      dll_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
      dll_q <= dll_d;
    end
  end

  assign cfg_o       = cfg_q;
  assign err_o       = err_q;
  assign dll_pulse_o = dll_q;

endmodule

// File: rtl/rdlat_pipe.sv
module rdlat_pipe #(
  parameter int LAT_FULL = 4,
  parameter int LAT_HALF = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic half_sel_i,
  output logic first_o,
  output logic first_half_o
);

  localparam int LANES = 2;

  logic [LANES-1:0] tap;
  logic             first_q, first_d;
  logic             half_q, half_d;

  for (genvar v = 0; v < LANES; v++) begin : g_lane
    localparam int D = (v == 0) ? LAT_FULL : LAT_HALF;
    logic [D-1:0] sr_q, sr_d;
    logic         lane_sel;

    assign lane_sel = (v == 1) ? half_sel_i : ~half_sel_i;

    always_comb begin
      sr_d    = sr_q << 1;
      sr_d[0] = launch_i & lane_sel;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= sr_d;
    end

    assign tap[v] = sr_q[D-1];
  end

  always_comb begin
    first_d = |tap;
    half_d  = tap[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      first_q <= first_d;
      half_q  <= half_d;
    end
  end

  assign first_o      = first_q;
  assign first_half_o = half_q;

endmodule

// File: rtl/mrs_rdlat_sched.sv
module mrs_rdlat_sched
  import mrs_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              load_i,
  input  logic              read_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [2:0]        bl_code_o,
  output logic              interleave_o,
  output logic              half_lat_o,
  output logic              dll_reset_o,
  output logic              cfg_err_o,
  output logic              first_data_o,
  output logic              first_half_o
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // Command qualification
  logic load_ok, read_ok;
  assign load_ok = rise_i & load_i & (bank_i == '0);
  assign read_ok = rise_i & read_i;

  mode_cfg_t cand, cfg;
  logic      bad, dll_req;

  mrs_field_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .cand_o    (cand),
    .bad_o     (bad),
    .dll_req_o (dll_req)
  );

  mrs_cfg_reg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .load_ok_i   (load_ok),
    .cand_i      (cand),
    .bad_i       (bad),
    .dll_req_i   (dll_req),
    .cfg_o       (cfg),
    .err_o       (cfg_err_o),
    .dll_pulse_o (dll_reset_o)
  );

  // The latency in force before this edge steers the read
  rdlat_pipe #(
    .LAT_FULL (LAT_FULL_TICKS),
    .LAT_HALF (LAT_HALF_TICKS)
  ) u_pipe (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .launch_i     (read_ok),
    .half_sel_i   (cfg.half),
    .first_o      (first_data_o),
    .first_half_o (first_half_o)
  );

  assign bl_code_o    = cfg.bl;
  assign interleave_o = cfg.il;
  assign half_lat_o   = cfg.half;

endmodule

// File: rtl/mrs_rdlat_sched_chk.sv
module mrs_rdlat_sched_chk #(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rise_i,
  input logic              load_i,
  input logic              read_i,
  input logic [BANK_W-1:0] bank_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [2:0]        bl_code_o,
  input logic              interleave_o,
  input logic              half_lat_o,
  input logic              dll_reset_o,
  input logic              cfg_err_o,
  input logic              first_data_o,
  input logic              first_half_o
);

  logic [2:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= 3'd0;
    else if (warm_q != 3'd7)  warm_q <= warm_q + 3'd1;
  end

  logic [4:0] fields;
  logic       rd_acc, base_ld, rsv;
  assign fields  = {bl_code_o, interleave_o, half_lat_o};
  assign rd_acc  = rise_i && read_i;
  assign base_ld = rise_i && load_i && (bank_i == '0);
  assign rsv = !(addr_i[2:0] inside {3'd1, 3'd2, 3'd3}) ||
               !(addr_i[6:4] inside {3'd2, 3'd6}) ||
               !((addr_i[ADDR_W-1:7] == '0) ||
                 (addr_i[ADDR_W-1:7] == (ADDR_W-7)'(2)));

  assert_dll_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_reset_o |=> !dll_reset_o);

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  assert_fall_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && load_i) |=> ($stable(fields) && !dll_reset_o));

  assert_other_bank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && load_i && bank_i != '0) |=> ($stable(fields) && $stable(cfg_err_o) && !dll_reset_o));

  assert_reserved_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_ld && rsv) |=> (cfg_err_o && $stable(fields) && !dll_reset_o));

  assert_full_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 3'd5 && $past(rd_acc, 5) && !$past(half_lat_o, 5)) |-> first_data_o);

  assert_half_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 3'd6 && $past(rd_acc, 6) && $past(half_lat_o, 6)) |-> (first_data_o && first_half_o));

  assert_half_implies_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_half_o |-> first_data_o);

  assert_marker_has_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 3'd6 && first_data_o) |->
      (($past(rd_acc, 5) && !$past(half_lat_o, 5)) || ($past(rd_acc, 6) && $past(half_lat_o, 6))));

endmodule

bind mrs_rdlat_sched mrs_rdlat_sched_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_n_int),
  .rise_i       (rise_i),
  .load_i       (load_i),
  .read_i       (read_i),
  .bank_i       (bank_i),
  .addr_i       (addr_i),
  .bl_code_o    (bl_code_o),
  .interleave_o (interleave_o),
  .half_lat_o   (half_lat_o),
  .dll_reset_o  (dll_reset_o),
  .cfg_err_o    (cfg_err_o),
  .first_data_o (first_data_o),
  .first_half_o (first_half_o)
);

// File: tb/mrs_rdlat_sched_tb_top.sv
`timescale 1ns/1ps
module mrs_rdlat_sched_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rise_i = 1'b0;
  logic        load_i = 1'b0;
  logic        read_i = 1'b0;
  logic [1:0]  bank_i = 2'b00;
  logic [13:0] addr_i = '0;
  logic [2:0]  bl_code_o;
  logic        interleave_o, half_lat_o, dll_reset_o, cfg_err_o;
  logic        first_data_o, first_half_o;

  always #2.5 clk_i = ~clk_i;

  mrs_rdlat_sched dut_i (
    .clk_i, .rst_ni, .rise_i, .load_i, .read_i, .bank_i, .addr_i,
    .bl_code_o, .interleave_o, .half_lat_o, .dll_reset_o, .cfg_err_o,
    .first_data_o, .first_half_o
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    ecount = 0;
  bit    done = 0;
  string ctx = "R1";

  logic [2:0] m_bl;
  logic       m_il, m_half, m_err, exp_dll;
  logic       ring_f [16];
  logic       ring_h [16];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h", tag, ctx, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_bl = 3'b001; m_il = 1'b0; m_half = 1'b0; m_err = 1'b0; exp_dll = 1'b0;
    for (int i = 0; i < 16; i++) begin ring_f[i] = 1'b0; ring_h[i] = 1'b0; end
  endtask

  // One tick: drive before the edge, check after it
  task automatic step(input logic ld, input logic rd, input logic [1:0] bk,
                      input logic [13:0] ad);
    int  e;
    bit  rs;
    bit  ok_bl, ok_cl, ok_op;
    int  idx;
    e  = ecount + 1;
    rs = (e % 2 == 0);
    rise_i = rs; load_i = ld; read_i = rd; bank_i = bk; addr_i = ad;
    exp_dll = 1'b0;
    if (rs && rd && rst_ni) begin
      idx = (e + (m_half ? 5 : 4)) % 16;
      ring_f[idx] = 1'b1;
      ring_h[idx] = m_half;
    end
    if (rs && ld && bk == 2'b00 && rst_ni) begin
      ok_bl = (ad[2:0] == 3'd1) || (ad[2:0] == 3'd2) || (ad[2:0] == 3'd3);
      ok_cl = (ad[6:4] == 3'd2) || (ad[6:4] == 3'd6);
      ok_op = (ad[13:7] == 7'd0) || (ad[13:7] == 7'd2);
      if (!(ok_bl && ok_cl && ok_op)) m_err = 1'b1;
      else begin
        m_bl = ad[2:0]; m_il = ad[3]; m_half = (ad[6:4] == 3'd6);
        exp_dll = (ad[13:7] == 7'd2);
      end
    end
    @(posedge clk_i);
    ecount++;
    @(negedge clk_i);
    idx = ecount % 16;
    chk(first_data_o == ring_f[idx], ring_h[idx] ? "R8" : "R7", "first_data",
        first_data_o, ring_f[idx]);
    chk(first_half_o == (ring_f[idx] & ring_h[idx]), "R8", "first_half",
        first_half_o, ring_f[idx] & ring_h[idx]);
    ring_f[idx] = 1'b0; ring_h[idx] = 1'b0;
    chk(dll_reset_o == exp_dll, "R6", "dll_reset", dll_reset_o, exp_dll);
    chk({bl_code_o, interleave_o, half_lat_o} == {m_bl, m_il, m_half}, "R4",
        "fields", {bl_code_o, interleave_o, half_lat_o}, {m_bl, m_il, m_half});
    chk(cfg_err_o == m_err, "R5", "err", cfg_err_o, m_err);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'b00, '0);
  endtask

  task automatic to_rise();
    if ((ecount + 1) % 2 != 0) idle(1);
  endtask

  task automatic to_fall();
    if ((ecount + 1) % 2 == 0) idle(1);
  endtask

  function automatic logic [13:0] mk(input logic [6:0] op, input logic [2:0] cl,
                                     input logic bt, input logic [2:0] bl);
    return {op, cl, bt, bl};
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    model_reset();
    idle(3);
    rst_ni = 1'b1;
    idle(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog [%s] actual=%0d expected=%0d", ctx, 1, 0);
    finish_run();
  end

  initial begin
    model_reset();
    ctx = "R1 reset state";
    do_reset();

    // R2: commands on falling ticks are ignored
    ctx = "R2 fall tick";
    to_fall();
    step(1'b1, 1'b1, 2'b00, mk(7'd2, 3'd6, 1'b1, 3'd3));
    idle(8);

    // R10: reads every clock at latency 2
    ctx = "R10 back-to-back CL2";
    to_rise();
    for (int i = 0; i < 6; i++) begin step(1'b0, 1'b1, 2'b00, '0); idle(1); end
    idle(8);

    // R6 + R4: switch to 2.5 with DLL reset
    ctx = "R6 dll load";
    to_rise();
    step(1'b1, 1'b0, 2'b00, mk(7'd2, 3'd6, 1'b0, 3'd2));
    idle(3);

    ctx = "R10 back-to-back CL2.5";
    to_rise();
    for (int i = 0; i < 6; i++) begin step(1'b0, 1'b1, 2'b00, '0); idle(1); end
    idle(8);

    // R9: load and read on the same edge, then more reads
    ctx = "R9 same-edge load+read";
    to_rise();
    step(1'b1, 1'b1, 2'b00, mk(7'd0, 3'd2, 1'b1, 3'd3));
    idle(1);
    step(1'b0, 1'b1, 2'b00, '0);
    idle(1);
    step(1'b1, 1'b1, 2'b00, mk(7'd0, 3'd6, 1'b0, 3'd1));
    idle(1);
    step(1'b0, 1'b1, 2'b00, '0);
    idle(10);

    // Sweep: R3 R4 R5 R6 R7 R8 R11 over all field codes and banks
    ctx = "sweep R3/R5/R11";
    for (int bk = 0; bk < 4; bk++)
      for (int oi = 0; oi < 4; oi++)
        for (int cl = 0; cl < 8; cl++)
          for (int bt = 0; bt < 2; bt++)
            for (int bl = 0; bl < 8; bl++) begin
              logic [6:0] op;
              op = (oi == 0) ? 7'd0 : (oi == 1) ? 7'd2 : (oi == 2) ? 7'd1 : 7'h40;
              to_rise();
              step(1'b1, 1'b0, 2'(bk), mk(op, 3'(cl), 1'(bt), 3'(bl)));
              idle(1);
              step(1'b0, 1'b1, 2'b00, '0);
              idle(6);
            end

    // R11: the error flag clears only through reset
    ctx = "R11 cleared by reset";
    do_reset();
    idle(2);
    finish_run();
  end

endmodule